// File: doc/BRIEF.md
# Freezable Performance Counter Bank

This block is a bank of eleven event counters that software reaches through a simple register port with valid, write, address and write-data inputs and a read-data output. Counter 0 is 64 bits wide and counts clock cycles. Counters 1 to 10 are 32 bits wide. Each of them adds one in every cycle in which the event line picked by its 7-bit select field is high. The event lines come in on a 128-bit input vector.

Counting can be stopped for the whole bank with one freeze-all bit, or for a single counter with that counter's own freeze bit. Software can write any count register, and writing 0 clears a counter. When bit 31 of a counter rises from 0 to 1, that counter has overflowed. If the overflow condition is enabled for that counter and both global enables are set, the block raises a level interrupt. The same interrupt also freezes the whole bank by setting the freeze-all bit. To recover, software writes the overflowed count back below the midpoint and then clears freeze-all.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter reads 0, the global register at 0x40 reads 0x8000_0000 (freeze-all set, both enables clear) and `irq` is low.
- R2: The global register at 0x40 holds freeze-all in bit 31, interrupt enable in bit 30 and freeze-on-condition enable in bit 29. Its other bits read 0.
- R3: Local control A of counter n is at 0x50+0x10·n. It holds the freeze bit in bit 31, the condition enable in bit 26 and the event select in bits 22:16, and its other bits read 0. Local control B at 0x54+0x10·n reads 0, and writes to it have no effect.
- R4: Counter n (1 to 10), read at 0x58+0x10·n, adds one in each cycle in which `events[select]` is 1, provided neither freeze-all nor its own freeze bit is set.
- R5: Counter 0 adds one in every unfrozen cycle, whatever its select field holds. Its low word is at 0x58 and its high word is at 0x5C.
- R6: A counter's own freeze bit stops only that counter. Freeze-all stops every counter.
- R7: Count registers are writable. A write takes priority over an increment in the same cycle.
- R8: `irq` is high exactly while interrupt enable, freeze-on-condition enable and at least one counter with its condition enable and bit 31 set are all present together.
- R9: While `irq` is high no counter advances, and from the next cycle freeze-all reads back as 1.
- R10: Writing the overflowed count below 0x8000_0000 drops `irq`. Clearing freeze-all afterwards lets counting resume.
- R11: A carry out of the low word of counter 0 increments its high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access valid |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data (combinational, 0 when no read) |
| events | input | 128 | Event pulse vector, one line per select code |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest state to reach from the ports is an overflow: a counter whose bit 31 rises while all three interrupt enables are set. Counting up to 2^31 event by event would take far too long. The bench instead writes a count just below the midpoint, holds the selected event high and unfreezes the bank, so the overflow and the self-freeze occur within two cycles. The exact frozen value, the freeze-all bit set by the hardware and the recovery sequence can then all be read back.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;
  localparam int NUM_CNT   = 11;
  localparam int CNT_W     = 32;
  localparam int CYC_W     = 64;
  localparam int SEL_W     = 7;
  localparam int ADDR_W    = 8;
  localparam int EVT_W     = 1 << SEL_W;
  localparam int STRIDE_LG = 4;
  localparam logic [ADDR_W-1:0] GLOBAL_ADDR = 8'h40;
  localparam logic [ADDR_W-1:0] LOCAL_BASE  = 8'h50;

  typedef struct packed {
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] wrLo;
    logic               wrHi;
    logic [CNT_W-1:0]   wdata;
  } strobe_t;
endpackage

// File: rtl/perf_bank_ctrl.sv
module perf_bank_ctrl
  import perf_bank_pkg::*;
#(
  parameter int NUM = NUM_CNT,
  parameter int DW  = CNT_W,
  parameter int AW  = ADDR_W,
  parameter int SW  = SEL_W,
  parameter int EW  = EVT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regValid,
  input  logic                   regWrite,
  input  logic [AW-1:0]          regAddr,
  input  logic [DW-1:0]          regWdata,
  output logic [DW-1:0]          regRdata,
  input  logic [EW-1:0]          events,
  input  logic [NUM-1:0][DW-1:0] cntVal,
  input  logic [DW-1:0]          cycHi,
  input  logic [NUM-1:0]         msb,
  output strobe_t                str,
  output logic                   freezeAllQ,
  output logic                   irq
);
  localparam int IDX_W = AW - STRIDE_LG;

  logic freezeAll, irqEn, fceEn;
  logic [NUM-1:0] locFrz, condEn;
  logic [NUM-1:0][SW-1:0] evSel;

  logic [AW-1:0]    offs;
  logic [IDX_W-1:0] idx;
  logic [1:0]       sub;
  logic hitGlb, hitCnt, wrGlb, wrLocA, haltAll;

  assign offs   = regAddr - LOCAL_BASE;
  assign idx    = offs[AW-1:STRIDE_LG];
  assign sub    = offs[3:2];
  assign hitGlb = regValid && (regAddr[AW-1:2] == GLOBAL_ADDR[AW-1:2]);
  assign hitCnt = regValid && (regAddr >= LOCAL_BASE) && (int'(idx) < NUM);
  assign wrGlb  = hitGlb && regWrite;
  assign wrLocA = hitCnt && regWrite && (sub == 2'd0);

  assign irq        = irqEn && fceEn && |(condEn & msb);
  assign haltAll    = freezeAll || irq;
  assign freezeAllQ = freezeAll;

  assign str.wdata = regWdata;
  assign str.wrHi  = hitCnt && regWrite && (sub == 2'd3) && (idx == '0);

  for (genvar i = 0; i < NUM; i++) begin : g_strobe
    assign str.wrLo[i] = hitCnt && regWrite && (sub == 2'd2) && (int'(idx) == i);
    if (i == 0) begin : g_cycle
      assign str.inc[i] = !haltAll && !locFrz[i];
    end else begin : g_event
      assign str.inc[i] = !haltAll && !locFrz[i] && events[evSel[i]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freezeAll <= 1'b1;
      irqEn     <= 1'b0;
      fceEn     <= 1'b0;
      locFrz    <= '0;
      condEn    <= '0;
      evSel     <= '0;
    end else begin
      if (wrGlb) begin
        freezeAll <= regWdata[31];
        irqEn     <= regWdata[30];
        fceEn     <= regWdata[29];
      end
      if (irq) freezeAll <= 1'b1;
      for (int i = 0; i < NUM; i++) begin
        if (wrLocA && int'(idx) == i) begin
          locFrz[i] <= regWdata[31];
          condEn[i] <= regWdata[26];
          evSel[i]  <= regWdata[22:16];
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (!regWrite) begin
      if (hitGlb) begin
        regRdata = {freezeAll, irqEn, fceEn, 29'b0};
      end else if (hitCnt) begin
        case (sub)
          2'd0: regRdata = {locFrz[idx], 4'b0, condEn[idx], 3'b0, evSel[idx], 16'b0};
          2'd2: regRdata = cntVal[idx];
          2'd3: regRdata = (idx == '0) ? cycHi : '0;
          default: regRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/perf_bank_datapath.sv
module perf_bank_datapath
  import perf_bank_pkg::*;
#(
  parameter int NUM = NUM_CNT,
  parameter int DW  = CNT_W,
  parameter int CW  = CYC_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                str,
  output logic [NUM-1:0][DW-1:0] cntLo,
  output logic [DW-1:0]          cycHi,
  output logic [NUM-1:0]         msb
);
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rstN)               cyc <= '0;
    else if (str.wrLo[0])    cyc[DW-1:0]  <= str.wdata;
    else if (str.wrHi)       cyc[CW-1:DW] <= str.wdata;
    else if (str.inc[0])     cyc <= cyc + 1'b1;
  end

  assign cntLo[0] = cyc[DW-1:0];
  assign cycHi    = cyc[CW-1:DW];
  assign msb[0]   = cyc[CW-1];

  for (genvar i = 1; i < NUM; i++) begin : g_cnt
    logic [DW-1:0] val;
    always_ff @(posedge clk) begin
      if (!rstN)            val <= '0;
      else if (str.wrLo[i]) val <= str.wdata;
      else if (str.inc[i])  val <= val + 1'b1;
    end
    assign cntLo[i] = val;
    assign msb[i]   = val[DW-1];
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic [EVT_W-1:0]  events,
  output logic              irq
);
  strobe_t                         str;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cntLo;
  logic [CNT_W-1:0]                cycHi;
  logic [NUM_CNT-1:0]              msbVec;
  logic                            freezeAllQ;

  perf_bank_ctrl #(
    .NUM(NUM_CNT), .DW(CNT_W), .AW(ADDR_W), .SW(SEL_W), .EW(EVT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .events(events), .cntVal(cntLo), .cycHi(cycHi), .msb(msbVec),
    .str(str), .freezeAllQ(freezeAllQ), .irq(irq)
  );

  perf_bank_datapath #(
    .NUM(NUM_CNT), .DW(CNT_W), .CW(CYC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .cntLo(cntLo), .cycHi(cycHi), .msb(msbVec)
  );
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int NUM = 11,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           irq,
  input logic           freezeAll,
  input logic [NUM-1:0] msb,
  input logic [NUM-1:0] inc,
  input logic [NUM-1:0] wrLo,
  input logic           wrHi,
  input logic [DW-1:0]  cnt1,
  input logic [2*DW-1:0] cyc
);
  logic anyWr;
  assign anyWr = (|wrLo) || wrHi;

  // R9: an interrupt sets freeze-all in the following cycle
  p_irq_sets_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> freezeAll);

  // R8: interrupt implies some counter has its top bit set
  p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (msb != '0));

  // R9: counters hold while the interrupt is up
  p_irq_halts_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !anyWr) |=> ($stable(cyc) && $stable(cnt1)));

  // R6: freeze-all holds every counter
  p_freeze_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    (freezeAll && !anyWr) |=> ($stable(cyc) && $stable(cnt1)));

  // R5: cycle counter steps by exactly one when enabled
  p_cycle_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inc[0] && !anyWr) |=> (cyc == $past(cyc) + 1'b1));
endmodule

bind perf_counter_bank perf_counter_bank_chk #(.NUM(perf_bank_pkg::NUM_CNT), .DW(perf_bank_pkg::CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .freezeAll(freezeAllQ), .msb(msbVec),
  .inc(str.inc), .wrLo(str.wrLo), .wrHi(str.wrHi), .cnt1(cntLo[1]),
  .cyc({cycHi, cntLo[0]})
);

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regValid, regWrite;
  logic [7:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic [127:0] events;
  logic        irq;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  perf_counter_bank u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .events(events), .irq(irq)
  );

  always #5 clk = ~clk;

  localparam logic [7:0] GLB = 8'h40;
  function automatic logic [7:0] aLoc(input int n); return 8'(8'h50 + 16 * n); endfunction
  function automatic logic [7:0] bLoc(input int n); return 8'(8'h54 + 16 * n); endfunction
  function automatic logic [7:0] aCnt(input int n); return 8'(8'h58 + 16 * n); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(GLB, v);      check("R1 global", v, 32'h8000_0000);
    rd(aCnt(1), v);  check("R1 cnt1", v, 32'h0);
    rd(aCnt(0), v);  check("R1 cycle", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(GLB, 32'hFFFF_FFFF);
    rd(GLB, v);      check("R2 global bits", v, 32'hE000_0000);
    wr(GLB, 32'h8000_0000);
    wr(aLoc(4), 32'hFFFF_FFFF);
    rd(aLoc(4), v);  check("R3 local A bits", v, 32'h847F_0000);
    wr(bLoc(4), 32'hFFFF_FFFF);
    rd(bLoc(4), v);  check("R3 local B ignored", v, 32'h0);
    wr(aLoc(4), 32'h8000_0000);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(aLoc(1), 32'h0005_0000);
    wr(aLoc(2), 32'h8005_0000);
    wr(aLoc(3), 32'h0006_0000);
    wr(aLoc(10), 32'h007F_0000);
    events = '0; events[5] = 1'b1; events[127] = 1'b1;
    wr(GLB, 32'h0);
    repeat (9) @(negedge clk);
    wr(GLB, 32'h8000_0000);
    rd(aCnt(1), v);  check("R4 selected event", v, 32'd10);
    rd(aCnt(2), v);  check("R6 local freeze", v, 32'd0);
    rd(aCnt(3), v);  check("R4 idle event", v, 32'd0);
    rd(aCnt(10), v); check("R4 select 127", v, 32'd10);
    rd(aCnt(0), v);  check("R5 cycles", v, 32'd10);
    repeat (3) @(negedge clk);
    rd(aCnt(1), v);  check("R6 freeze-all holds", v, 32'd10);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(GLB, 32'h0);
    wr(aCnt(1), 32'h100);
    wr(GLB, 32'h8000_0000);
    rd(aCnt(1), v);  check("R7 write wins", v, 32'h101);
    rd(aCnt(0), v);  check("R5 cycles resumed", v, 32'd12);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    wr(aCnt(0), 32'hFFFF_FFFF);
    wr(8'h5C, 32'h1);
    wr(GLB, 32'h0);
    wr(GLB, 32'h8000_0000);
    rd(aCnt(0), v);  check("R11 low wraps", v, 32'h0);
    rd(8'h5C, v);    check("R11 high carry", v, 32'h2);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    events = '0; events[7] = 1'b1;
    wr(aLoc(3), 32'h0407_0000);
    wr(aCnt(3), 32'h7FFF_FFFE);
    wr(GLB, 32'h6000_0000);
    repeat (5) @(negedge clk);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    rd(aCnt(3), v);  check("R9 halted at overflow", v, 32'h8000_0000);
    rd(GLB, v);      check("R9 hardware freeze", v, 32'hE000_0000);
    rd(aCnt(0), v);  check("R9 cycle halted", v, 32'd2);
    wr(aCnt(3), 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    wr(GLB, 32'h6000_0000);
    repeat (3) @(negedge clk);
    wr(GLB, 32'h8000_0000);
    rd(aCnt(3), v);  check("R10 resumed", v, 32'd4);
  endtask

  task automatic t_gate();
    wr(GLB, 32'hC000_0000);
    wr(aCnt(3), 32'h8000_0000);
    check("R8 needs freeze-on-condition", {31'b0, irq}, 32'h0);
    wr(GLB, 32'hE000_0000);
    check("R8 all enables", {31'b0, irq}, 32'h1);
    wr(aLoc(3), 32'h0007_0000);
    check("R8 needs condition enable", {31'b0, irq}, 32'h0);
    wr(GLB, 32'h8000_0000);
    wr(aCnt(3), 32'h0);
  endtask

  initial begin
    rstN = 1'b0; regValid = 1'b0; regWrite = 1'b0;
    regAddr = '0; regWdata = '0; events = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count();
    t_priority();
    t_carry();
    t_overflow();
    t_gate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule